// File: doc/BRIEF.md
# Banked Internal Data Memory Unit

This block is the 128-byte on-chip working store of an 8-bit accumulator CPU. One storage array is seen through several views at once. The lowest 32 bytes hold four banks of eight working registers, and a bank register picks the active bank. The 16 bytes from 20h to 2Fh can also be reached one bit at a time through a 7-bit bit address. An 8-bit stack pointer drives push and pop strobes into the same array. The remaining bytes from 30h to 7Fh are plain scratch storage.

Four ports reach the array:

- A byte port reads and writes any byte. It takes either a direct 7-bit address or an indirect address held in R0 or R1 of the active bank.
- A register port reads and writes a working register by its 3-bit number within the active bank.
- A bit port sets, clears or reads a single bit.
- A stack port pushes and pops bytes.

Every read returns its data one clock after the request. A bit set or clear is a one-cycle read-modify-write. When two write ports hit the same byte in one cycle, a fixed priority decides which value is kept.

The stack logic is a two-state machine. READY is the state after reset. FAULT is entered on the transition taken by any push or pop whose target lies outside the array. There is no transition back out of FAULT except reset. The stack-fault output is high in FAULT.

Top module: `idata_top`

## Requirements
- R1: After reset the stack pointer is 07h, the active bank is 0, stack fault is low, every read-data output is 0, and every byte of the array reads 00h.
- R2: Register r (reg_num, 0 to 7) of bank b is byte b*8+r. A write through the register port is visible at that byte address on the byte port, and a direct byte write is visible through the register port.
- R3: The active bank is loaded from bank_d in the clock where bank_we is high and holds otherwise. It is used by the register port and by indirect addressing.
- R4: With byte_ind high, the byte port address is the low 7 bits of R0 (byte_ptr_sel=0) or R1 (byte_ptr_sel=1) of the active bank. With byte_ind low, the address is byte_addr.
- R5: bit_op encodes 00 none, 01 set, 10 clear and 11 read. Bit address n refers to bit n mod 8 of byte 20h + n div 8. A set or clear changes only that bit. A read returns the bit on bit_rdata. Code 00 changes nothing.
- R6: A push with the stack pointer below 7Fh first increments the pointer and then writes push_data at the new value. From reset, the first push writes byte 08h.
- R7: A pop alone with the stack pointer below 80h returns the byte at the current pointer on pop_data and then decrements the pointer. A pop at 00h leaves the pointer at FFh.
- R8: A push with the pointer at 7Fh or above, or a pop alone with the pointer at 80h or above, is out of range. It leaves the array and the pointer unchanged and moves the stack machine from READY to FAULT. stk_fault then stays high until reset.
- R9: When writes land on the same byte in one cycle, the byte port wins over the register port, the register port wins over the bit port, and the bit port wins over a push. A push that loses still moves the pointer.
- R10: Every read output updates one clock after its request and returns the byte's value from before any write in that same cycle. A read output holds while its port is idle.
- R11: When push and pop are both high, only the push is performed. The pointer rises by one and pop_data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_we | input | 1 | Load the active bank |
| bank_d | input | 2 | New bank value |
| bank_q | output | 2 | Active bank |
| byte_en | input | 1 | Byte port request |
| byte_we | input | 1 | Byte port write (with byte_en) |
| byte_ind | input | 1 | 1: indirect via R0/R1, 0: direct |
| byte_ptr_sel | input | 1 | Indirect pointer: 0 R0, 1 R1 |
| byte_addr | input | 7 | Direct byte address |
| byte_wdata | input | 8 | Byte write data |
| byte_rdata | output | 8 | Byte read data, one clock later |
| reg_en | input | 1 | Register port request |
| reg_we | input | 1 | Register port write (with reg_en) |
| reg_num | input | 3 | Register number in active bank |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, one clock later |
| bit_op | input | 2 | 00 none, 01 set, 10 clear, 11 read |
| bit_addr | input | 7 | Bit address |
| bit_rdata | output | 1 | Bit read data, one clock later |
| push | input | 1 | Push strobe |
| pop | input | 1 | Pop strobe |
| push_data | input | 8 | Byte to push |
| pop_data | output | 8 | Popped byte, one clock later |
| sp | output | 8 | Stack pointer |
| stk_fault | output | 1 | Sticky out-of-range stack error |

## Verification
The checker watches these rules on every cycle:

- the pointer steps by exactly one on each legal push or pop;
- the pointer stays put, and the fault rises, on each out-of-range request;
- once raised, the fault never falls;
- the bank changes only on a load;
- pop data and bit data hold when no read of theirs takes place.

Only the bench scenarios can show where data actually lands in the array: the aliasing between banked registers and byte addresses, the bit-to-byte mapping, indirect addressing through R0 and R1, and which value survives a write collision. They can also show that an out-of-range push does not wrap into byte 00h.

// File: rtl/idata_pkg.sv
package idata_pkg;

    typedef enum logic [1:0] {
        BOP_NONE = 2'b00,
        BOP_SET  = 2'b01,
        BOP_CLR  = 2'b10,
        BOP_READ = 2'b11
    } bit_op_e;

    typedef enum logic {
        STK_READY = 1'b0,
        STK_FAULT = 1'b1
    } stk_state_e;

endpackage

// File: rtl/idata_addr.sv
module idata_addr #(
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 8,
    parameter int REG_W    = 3,
    parameter int BANK_W   = 2,
    parameter int BIT_BASE = 32
) (
    input  logic [BANK_W-1:0]          bank_q,
    input  logic [REG_W-1:0]           reg_num,
    input  logic                       ptr_sel,
    input  logic [ADDR_W-1:0]          ptr_val,
    input  logic                       byte_ind,
    input  logic [ADDR_W-1:0]          byte_addr,
    input  logic [ADDR_W-1:0]          bit_addr,
    output logic [ADDR_W-1:0]          reg_byte,
    output logic [ADDR_W-1:0]          ptr_byte,
    output logic [ADDR_W-1:0]          eff_byte,
    output logic [ADDR_W-1:0]          bit_byte,
    output logic [$clog2(DATA_W)-1:0]  bit_idx
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int PAD_W = ADDR_W - BANK_W - REG_W;
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BIT_BASE);

    // bank*8 + register number
    assign reg_byte = {{PAD_W{1'b0}}, bank_q, reg_num};
    // R0 or R1 of the active bank
    assign ptr_byte = {{PAD_W{1'b0}}, bank_q, {(REG_W-1){1'b0}}, ptr_sel};
    assign eff_byte = byte_ind ? ptr_val : byte_addr;
    // bit n -> byte BASE + n/8, bit n%8
    assign bit_byte = BASE + {{IDX_W{1'b0}}, bit_addr[ADDR_W-1:IDX_W]};
    assign bit_idx  = bit_addr[IDX_W-1:0];

endmodule

// File: rtl/idata_stack.sv
module idata_stack
    import idata_pkg::*;
#(
    parameter int SP_W     = 8,
    parameter int ADDR_W   = 7,
    parameter int SP_RESET = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    output logic [SP_W-1:0]   sp_q,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              fault
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [SP_W:0] LIMIT = (SP_W+1)'(DEPTH);

    stk_state_e state_q, state_d;
    logic [SP_W:0] sp_inc;
    logic push_req, pop_req, push_ok, pop_ok, out_of_range;

    assign sp_inc       = {1'b0, sp_q} + 1'b1;
    assign push_req     = push;
    assign pop_req      = pop && !push;
    assign push_ok      = push_req && (sp_inc < LIMIT);
    assign pop_ok       = pop_req && ({1'b0, sp_q} < LIMIT);
    assign out_of_range = (push_req && !push_ok) || (pop_req && !pop_ok);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= STK_READY;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STK_READY: if (out_of_range) state_d = STK_FAULT;
            STK_FAULT: state_d = STK_FAULT;
        endcase
    end

    // outputs
    always_comb begin
        fault   = (state_q == STK_FAULT);
        wr_en   = push_ok;
        wr_addr = sp_inc[ADDR_W-1:0];
        rd_en   = pop_ok;
        rd_addr = sp_q[ADDR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sp_q <= SP_W'(SP_RESET);
        else if (push_ok) sp_q <= sp_inc[SP_W-1:0];
        else if (pop_ok)  sp_q <= sp_q - 1'b1;
    end

endmodule

// File: rtl/idata_array.sv
module idata_array #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       a_en,
    input  logic [ADDR_W-1:0]          a_addr,
    input  logic [DATA_W-1:0]          a_data,
    input  logic                       b_en,
    input  logic [ADDR_W-1:0]          b_addr,
    input  logic [DATA_W-1:0]          b_data,
    input  logic                       c_en,
    input  logic [ADDR_W-1:0]          c_addr,
    input  logic [$clog2(DATA_W)-1:0]  c_idx,
    input  logic                       c_val,
    input  logic                       d_en,
    input  logic [ADDR_W-1:0]          d_addr,
    input  logic [DATA_W-1:0]          d_data,
    input  logic [ADDR_W-1:0]          ptr_addr,
    output logic [ADDR_W-1:0]          ptr_data,
    input  logic                       rb_en,
    input  logic [ADDR_W-1:0]          rb_addr,
    output logic [DATA_W-1:0]          rb_q,
    input  logic                       rr_en,
    input  logic [ADDR_W-1:0]          rr_addr,
    output logic [DATA_W-1:0]          rr_q,
    input  logic                       rt_en,
    input  logic [ADDR_W-1:0]          rt_addr,
    input  logic [$clog2(DATA_W)-1:0]  rt_idx,
    output logic                       rt_q,
    input  logic                       rp_en,
    input  logic [ADDR_W-1:0]          rp_addr,
    output logic [DATA_W-1:0]          rp_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [DATA_W-1:0] cell_q;
        // per-byte write priority: byte > register > bit > push
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cell_q <= '0;
            else if (a_en && a_addr == ADDR_W'(g))
                cell_q <= a_data;
            else if (b_en && b_addr == ADDR_W'(g))
                cell_q <= b_data;
            else if (c_en && c_addr == ADDR_W'(g))
                cell_q[c_idx] <= c_val;
            else if (d_en && d_addr == ADDR_W'(g))
                cell_q <= d_data;
        end
        assign mem[g] = cell_q;
    end

    assign ptr_data = mem[ptr_addr][ADDR_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_q <= '0;
            rr_q <= '0;
            rt_q <= 1'b0;
            rp_q <= '0;
        end else begin
            if (rb_en) rb_q <= mem[rb_addr];
            if (rr_en) rr_q <= mem[rr_addr];
            if (rt_en) rt_q <= mem[rt_addr][rt_idx];
            if (rp_en) rp_q <= mem[rp_addr];
        end
    end

endmodule

// File: rtl/idata_top.sv
module idata_top
    import idata_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 8,
    parameter int REG_W    = 3,
    parameter int BANK_W   = 2,
    parameter int SP_W     = 8,
    parameter int BIT_BASE = 32,
    parameter int SP_RESET = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_we,
    input  logic [BANK_W-1:0] bank_d,
    output logic [BANK_W-1:0] bank_q,
    input  logic              byte_en,
    input  logic              byte_we,
    input  logic              byte_ind,
    input  logic              byte_ptr_sel,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [DATA_W-1:0] byte_wdata,
    output logic [DATA_W-1:0] byte_rdata,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_num,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [1:0]        bit_op,
    input  logic [ADDR_W-1:0] bit_addr,
    output logic              bit_rdata,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] pop_data,
    output logic [SP_W-1:0]   sp,
    output logic              stk_fault
);
    localparam int IDX_W = $clog2(DATA_W);

    bit_op_e op;
    assign op = bit_op_e'(bit_op);

    logic [ADDR_W-1:0] reg_byte, ptr_byte, eff_byte, bit_byte, ptr_val;
    logic [IDX_W-1:0]  bit_idx;
    logic              stk_wr, stk_rd;
    logic [ADDR_W-1:0] stk_wr_addr, stk_rd_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       bank_q <= '0;
        else if (bank_we) bank_q <= bank_d;
    end

    idata_addr #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W),
        .BANK_W(BANK_W), .BIT_BASE(BIT_BASE)
    ) u_addr (
        .bank_q    (bank_q),
        .reg_num   (reg_num),
        .ptr_sel   (byte_ptr_sel),
        .ptr_val   (ptr_val),
        .byte_ind  (byte_ind),
        .byte_addr (byte_addr),
        .bit_addr  (bit_addr),
        .reg_byte  (reg_byte),
        .ptr_byte  (ptr_byte),
        .eff_byte  (eff_byte),
        .bit_byte  (bit_byte),
        .bit_idx   (bit_idx)
    );

    idata_stack #(
        .SP_W(SP_W), .ADDR_W(ADDR_W), .SP_RESET(SP_RESET)
    ) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .pop     (pop),
        .sp_q    (sp),
        .wr_en   (stk_wr),
        .wr_addr (stk_wr_addr),
        .rd_en   (stk_rd),
        .rd_addr (stk_rd_addr),
        .fault   (stk_fault)
    );

    idata_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_en     (byte_en && byte_we),
        .a_addr   (eff_byte),
        .a_data   (byte_wdata),
        .b_en     (reg_en && reg_we),
        .b_addr   (reg_byte),
        .b_data   (reg_wdata),
        .c_en     (op == BOP_SET || op == BOP_CLR),
        .c_addr   (bit_byte),
        .c_idx    (bit_idx),
        .c_val    (op == BOP_SET),
        .d_en     (stk_wr),
        .d_addr   (stk_wr_addr),
        .d_data   (push_data),
        .ptr_addr (ptr_byte),
        .ptr_data (ptr_val),
        .rb_en    (byte_en),
        .rb_addr  (eff_byte),
        .rb_q     (byte_rdata),
        .rr_en    (reg_en),
        .rr_addr  (reg_byte),
        .rr_q     (reg_rdata),
        .rt_en    (op == BOP_READ),
        .rt_addr  (bit_byte),
        .rt_idx   (bit_idx),
        .rt_q     (bit_rdata),
        .rp_en    (stk_rd),
        .rp_addr  (stk_rd_addr),
        .rp_q     (pop_data)
    );

endmodule

// File: rtl/idata_chk.sv
module idata_chk #(
    parameter int SP_W   = 8,
    parameter int ADDR_W = 7,
    parameter int BANK_W = 2,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bank_we,
    input logic [BANK_W-1:0] bank_d,
    input logic [BANK_W-1:0] bank_q,
    input logic [1:0]        bit_op,
    input logic              bit_rdata,
    input logic              push,
    input logic              pop,
    input logic [DATA_W-1:0] pop_data,
    input logic [SP_W-1:0]   sp,
    input logic              stk_fault
);
    localparam logic [SP_W-1:0] LAST = SP_W'((1 << ADDR_W) - 1);
    localparam logic [SP_W-1:0] END  = SP_W'(1 << ADDR_W);

    p_push_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && sp < LAST) |=> (sp == $past(sp) + 1'b1));

    p_pop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && sp < END) |=> (sp == $past(sp) - 1'b1));

    p_range_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((push && sp >= LAST) || (pop && !push && sp >= END))
        |=> ($stable(sp) && stk_fault));

    p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stk_fault |=> stk_fault);

    p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_we |=> $stable(bank_q));

    p_bank_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |=> (bank_q == $past(bank_d)));

    p_pop_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> $stable(pop_data));

    p_bit_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_op != 2'b11) |=> $stable(bit_rdata));

endmodule

bind idata_top idata_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_we   (bank_we),
    .bank_d    (bank_d),
    .bank_q    (bank_q),
    .bit_op    (bit_op),
    .bit_rdata (bit_rdata),
    .push      (push),
    .pop       (pop),
    .pop_data  (pop_data),
    .sp        (sp),
    .stk_fault (stk_fault)
);

// File: tb/idata_top_bench.sv
module idata_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bank_we = 0;
    logic [1:0] bank_d = 0;
    logic [1:0] bank_q;
    logic       byte_en = 0, byte_we = 0, byte_ind = 0, byte_ptr_sel = 0;
    logic [6:0] byte_addr = 0;
    logic [7:0] byte_wdata = 0;
    logic [7:0] byte_rdata;
    logic       reg_en = 0, reg_we = 0;
    logic [2:0] reg_num = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic [1:0] bit_op = 0;
    logic [6:0] bit_addr = 0;
    logic       bit_rdata;
    logic       push = 0, pop = 0;
    logic [7:0] push_data = 0;
    logic [7:0] pop_data;
    logic [7:0] sp;
    logic       stk_fault;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    idata_top u_idata_top (
        .clk(clk), .rst_n(rst_n),
        .bank_we(bank_we), .bank_d(bank_d), .bank_q(bank_q),
        .byte_en(byte_en), .byte_we(byte_we), .byte_ind(byte_ind),
        .byte_ptr_sel(byte_ptr_sel), .byte_addr(byte_addr),
        .byte_wdata(byte_wdata), .byte_rdata(byte_rdata),
        .reg_en(reg_en), .reg_we(reg_we), .reg_num(reg_num),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bit_op(bit_op), .bit_addr(bit_addr), .bit_rdata(bit_rdata),
        .push(push), .pop(pop), .push_data(push_data), .pop_data(pop_data),
        .sp(sp), .stk_fault(stk_fault)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        bank_we = 0; byte_en = 0; byte_we = 0; byte_ind = 0; byte_ptr_sel = 0;
        reg_en = 0; reg_we = 0; bit_op = 2'b00; push = 0; pop = 0;
    endtask

    // inputs are set just after a falling edge; the rising edge acts;
    // outputs are sampled at the following falling edge
    task automatic cycle();
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic set_bank(input logic [1:0] b);
        bank_we = 1; bank_d = b; cycle();
    endtask

    task automatic byte_wr(input logic [6:0] a, input logic [7:0] d);
        byte_en = 1; byte_we = 1; byte_addr = a; byte_wdata = d; cycle();
    endtask

    task automatic byte_rd(input logic [6:0] a, output logic [7:0] d);
        byte_en = 1; byte_addr = a; cycle(); d = byte_rdata;
    endtask

    task automatic ind_wr(input logic s, input logic [7:0] d);
        byte_en = 1; byte_we = 1; byte_ind = 1; byte_ptr_sel = s; byte_wdata = d; cycle();
    endtask

    task automatic reg_wr(input logic [2:0] n, input logic [7:0] d);
        reg_en = 1; reg_we = 1; reg_num = n; reg_wdata = d; cycle();
    endtask

    task automatic reg_rd(input logic [2:0] n, output logic [7:0] d);
        reg_en = 1; reg_num = n; cycle(); d = reg_rdata;
    endtask

    task automatic bit_do(input logic [1:0] op, input logic [6:0] a);
        bit_op = op; bit_addr = a; cycle();
    endtask

    task automatic do_push(input logic [7:0] d);
        push = 1; push_data = d; cycle();
    endtask

    task automatic do_pop(output logic [7:0] d);
        pop = 1; cycle(); d = pop_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 sp", sp, 8'h07);
        chk("R1 bank", bank_q, 0);
        chk("R1 fault", stk_fault, 0);
        chk("R1 byte_rdata", byte_rdata, 0);
        chk("R1 pop_data", pop_data, 0);
        byte_rd(7'h55, v);
        chk("R1 array cleared", v, 0);
    endtask

    task automatic t_regbank();
        logic [7:0] v;
        for (int b = 0; b < 4; b++) begin
            set_bank(2'(b));
            chk("R3 bank load", bank_q, b);
            reg_wr(3'd5, 8'hA0 + 8'(b));
        end
        for (int b = 0; b < 4; b++) begin
            byte_rd(7'(b * 8 + 5), v);
            chk("R2 reg alias byte", v, 8'hA0 + 8'(b));
        end
        byte_wr(7'h1A, 8'h6B);
        reg_rd(3'd2, v);           // bank 3, R2 = byte 1Ah
        chk("R2 byte alias reg", v, 8'h6B);
        set_bank(2'd0);
        reg_rd(3'd2, v);           // bank 0 R2 = byte 02h, untouched
        chk("R3 bank selects", v, 8'h00);
    endtask

    task automatic t_indirect();
        logic [7:0] v;
        set_bank(2'd2);
        reg_wr(3'd1, 8'h45);
        ind_wr(1'b1, 8'h3C);
        byte_rd(7'h45, v);
        chk("R4 indirect R1", v, 8'h3C);
        reg_wr(3'd0, 8'hC6);       // low 7 bits = 46h
        ind_wr(1'b0, 8'h91);
        byte_rd(7'h46, v);
        chk("R4 indirect R0 low bits", v, 8'h91);
        set_bank(2'd0);
    endtask

    task automatic t_bits();
        logic [7:0] v;
        byte_wr(7'h28, 8'h00);
        bit_do(2'b01, 7'h42);
        byte_rd(7'h28, v);
        chk("R5 set 42h", v, 8'h04);
        byte_wr(7'h21, 8'h00);
        bit_do(2'b01, 7'h0F);
        byte_rd(7'h21, v);
        chk("R5 set 0Fh", v, 8'h80);
        byte_wr(7'h20, 8'hFF);
        bit_do(2'b10, 7'h05);
        byte_rd(7'h20, v);
        chk("R5 clear 05h", v, 8'hDF);
        bit_do(2'b11, 7'h05);
        chk("R5 read 05h", bit_rdata, 0);
        bit_do(2'b11, 7'h06);
        chk("R5 read 06h", bit_rdata, 1);
        bit_do(2'b00, 7'h40);
        byte_rd(7'h28, v);
        chk("R5 op none", v, 8'h04);
    endtask

    task automatic t_readfirst();
        logic [7:0] v;
        byte_wr(7'h30, 8'h12);
        byte_wr(7'h30, 8'h34);
        chk("R10 read-before-write", byte_rdata, 8'h12);
        byte_rd(7'h30, v);
        chk("R10 new value", v, 8'h34);
        cycle();
        chk("R10 idle hold", byte_rdata, 8'h34);
    endtask

    task automatic t_stack();
        logic [7:0] v;
        do_push(8'h11);
        chk("R6 sp after push", sp, 8'h08);
        byte_rd(7'h08, v);
        chk("R6 first push at 08h", v, 8'h11);
        do_push(8'h22);
        chk("R6 sp second push", sp, 8'h09);
        do_pop(v);
        chk("R7 pop data", v, 8'h22);
        chk("R7 sp after pop", sp, 8'h08);
        do_pop(v);
        chk("R7 pop data 2", v, 8'h11);
        chk("R7 sp back", sp, 8'h07);
    endtask

    task automatic t_pushpop();
        logic [7:0] v;
        push = 1; pop = 1; push_data = 8'h33; cycle();
        chk("R11 sp", sp, 8'h08);
        chk("R11 pop_data held", pop_data, 8'h11);
        byte_rd(7'h08, v);
        chk("R11 push written", v, 8'h33);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        // byte vs bit on byte 2Ah (bit 57h = byte 2Ah bit 7)
        byte_en = 1; byte_we = 1; byte_addr = 7'h2A; byte_wdata = 8'h0F;
        bit_op = 2'b01; bit_addr = 7'h57; cycle();
        byte_rd(7'h2A, v);
        chk("R9 byte over bit", v, 8'h0F);
        // register vs push on byte 09h (bank 1 R1), sp = 08h
        set_bank(2'd1);
        reg_en = 1; reg_we = 1; reg_num = 3'd1; reg_wdata = 8'h77;
        push = 1; push_data = 8'h66; cycle();
        chk("R9 losing push moves sp", sp, 8'h09);
        byte_rd(7'h09, v);
        chk("R9 reg over push", v, 8'h77);
        // byte vs push on byte 0Ah
        byte_en = 1; byte_we = 1; byte_addr = 7'h0A; byte_wdata = 8'hAA;
        push = 1; push_data = 8'h55; cycle();
        byte_rd(7'h0A, v);
        chk("R9 byte over push", v, 8'hAA);
        set_bank(2'd0);
        // bit vs push on byte 21h
        while (sp < 8'h20) do_push(8'h00);
        byte_wr(7'h21, 8'h00);
        bit_op = 2'b01; bit_addr = 7'h0F; push = 1; push_data = 8'h01; cycle();
        byte_rd(7'h21, v);
        chk("R9 bit over push", v, 8'h80);
        chk("R9 sp after bit collision", sp, 8'h21);
    endtask

    task automatic t_range();
        logic [7:0] v;
        byte_wr(7'h00, 8'h5A);
        while (sp < 8'h7F) do_push(8'(sp) ^ 8'hC3);
        chk("R8 no fault in range", stk_fault, 0);
        byte_rd(7'h7F, v);
        chk("R6 last legal push", v, 8'h7E ^ 8'hC3);
        do_push(8'hEE);
        chk("R8 push sp held", sp, 8'h7F);
        chk("R8 push fault", stk_fault, 1);
        byte_rd(7'h00, v);
        chk("R8 no wrap write", v, 8'h5A);
        while (sp != 8'h00) do_pop(v);
        do_pop(v);
        chk("R7 pop at 00h data", v, 8'h5A);
        chk("R7 pop at 00h sp", sp, 8'hFF);
        do_pop(v);
        chk("R8 pop out of range sp", sp, 8'hFF);
        chk("R8 pop out of range data", v, 8'h5A);
        repeat (3) cycle();
        chk("R8 fault sticky", stk_fault, 1);
        rst_n = 0; cycle(); rst_n = 1; cycle();
        chk("R1 fault cleared", stk_fault, 0);
        chk("R1 sp reset", sp, 8'h07);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_regbank();
        t_indirect();
        t_bits();
        t_readfirst();
        t_stack();
        t_pushpop();
        t_collide();
        t_range();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all requirements actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule